// File: doc/BRIEF.md
# Receive Destination Address Screen

This block sits at the front of an Ethernet receive path and decides, from the destination address alone, whether a frame is kept. The first six octets of each frame arrive as a byte stream. A start pulse marks the first byte, and an end pulse marks the last byte of the frame. While the bytes arrive, the block assembles the address and runs a CRC-32 over it one byte per cycle. Once the sixth byte has been taken, it classifies the address into one of three classes:

- **Broadcast**: all ones.
- **Hashed**: group addresses, or every non-broadcast address when the hash-all control is set.
- **Individual**: everything else, compared with the station address.

The block then registers a decision.

The decision has two flags:

- **miss**: the address did not pass its filter.
- **accept**: the frame is kept.

Promiscuous mode keeps a frame that missed, and the miss flag still reports that it missed. The descriptor logic can then store it. The decision stays unchanged until the next start pulse. That pulse clears it and restarts the CRC and the address capture. Frame length, padding and storage are handled elsewhere.

Top module: `rx_dest_screen`

## Requirements
- R1: After reset, and at any time no decision is present, `dec_vld`, `accept` and `miss` are all 0.
- R2: Byte 0 is the byte taken on the cycle with `frm_start` and `byte_vld` both high. Later bytes are taken on cycles with `byte_vld` high. If the sixth byte is taken at rising edge E, then `dec_vld` is still 0 just after E and becomes 1 just after edge E+1. Bytes after the sixth do not change the decision.
- R3: An address of all ones (0xFF in all six bytes) is a miss exactly when `ctl_bcast_rej` is 1.
- R4: A non-broadcast address uses the hash table when bit 0 of byte 0 is 1, or when `ctl_hash_all` is 1.
- R5: For a hashed address, the CRC register starts at all ones. Each byte is fed least significant bit first. For each bit, the register shifts left, and 0x04C11DB7 is XORed in when the old bit 31 differs from the data bit. No final inversion is applied. The index is bits 31:26 of the result.
  - Indices 0 to 31 select bit (index) of `hash_lo`.
  - Indices 32 to 63 select bit (index-32) of `hash_hi`.
  - A selected bit of 0 is a miss.
- R6: Any other address is compared with the station address, and any difference is a miss. The station address is laid out as follows:
  - Byte 0 is `stn_hi[15:8]` and byte 1 is `stn_hi[7:0]`.
  - Bytes 2 to 5 are `stn_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R7: If `frm_end` arrives with fewer than six bytes taken (zero to five), the decision is a miss, with the same one-cycle latency after the edge that takes `frm_end`.
- R8: `miss` reports the filter result. `accept` equals (not miss) or `ctl_promisc`. This means a missed frame is accepted, with `miss`=1, only in promiscuous mode.
- R9: A decision holds unchanged while no `frm_start` occurs. A `frm_start` clears `dec_vld`, `accept` and `miss` at the next edge and starts a new address and CRC, so back-to-back frames are judged independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | First-byte marker; restarts capture and clears the decision |
| byte_vld | input | 1 | Byte on `byte_dat` is valid this cycle |
| byte_dat | input | 8 | Received byte, destination address first |
| frm_end | input | 1 | Marks the final byte (or an empty frame) |
| stn_hi | input | ADDR_BYTES*8-32 | Station address bytes 0 and 1 |
| stn_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash table bits for indices 0..31 |
| hash_hi | input | 32 | Hash table bits for indices 32..63 |
| ctl_bcast_rej | input | 1 | Treat broadcast as a miss |
| ctl_hash_all | input | 1 | Hash every non-broadcast address |
| ctl_promisc | input | 1 | Accept frames that miss |
| dec_vld | output | 1 | Decision present |
| accept | output | 1 | Frame is kept |
| miss | output | 1 | Address failed its filter |

## Verification
The hash path is swept over 64 group addresses. For each one, the bench computes the CRC index arithmetically and programs a table holding only that bit, then the same table with only that bit cleared. This tells a correct index and half-select apart from any off-by-one or bit-order fault. The individual path is tried with an exact match and with a single flipped bit in each of the six byte positions, which separates the per-byte placement of the station registers. Broadcast is tried under both settings of the reject control. Frames of zero to five bytes are sent with an otherwise matching address, both plain and promiscuous. Trailing bytes, the decision latency, the hold behaviour and back-to-back frames with different classes show that the capture restarts on each start pulse.

// File: rtl/rx_dest_pkg.sv
package rx_dest_pkg;

  localparam int unsigned OCTET_W  = 8;
  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  // one byte of the CRC, data bits taken LSB first, MSB-shifting register
  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] c_in,
                                                 input logic [OCTET_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int j = 0; j < OCTET_W; j++) begin
      fb = c[CRC_W-1] ^ d[j];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_dest_capture.sv
module rx_dest_capture
  import rx_dest_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_start,
  input  logic               byte_vld,
  input  logic [OCTET_W-1:0] byte_dat,
  input  logic               frm_end,
  output logic               take,
  output logic [ADDR_W-1:0]  addr_flat,
  output logic               done_q,
  output logic               short_q
);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   pos;
  logic               armed_q;
  logic               active;
  logic               fin_full;
  logic               fin_short;
  logic [OCTET_W-1:0] addr_q [ADDR_BYTES];

  assign active    = frm_start || armed_q;
  assign pos       = frm_start ? '0 : cnt_q;
  assign take      = byte_vld && active;
  assign fin_full  = take && (pos == CNT_W'(ADDR_BYTES - 1));
  assign fin_short = active && frm_end && !fin_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      armed_q <= active && !fin_full && !fin_short;
      cnt_q   <= active ? pos + CNT_W'(take) : '0;
      done_q  <= fin_full || fin_short;
      short_q <= fin_short;
    end
  end

  // byte store: no reset needed, suits distributed RAM/registers
  always_ff @(posedge clk) begin
    if (take) addr_q[pos] <= byte_dat;
  end

  generate
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_flat
      assign addr_flat[ADDR_W-1-i*OCTET_W -: OCTET_W] = addr_q[i];
    end
  endgenerate

endmodule

// File: rtl/rx_dest_crc.sv
module rx_dest_crc
  import rx_dest_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               take,
  input  logic [OCTET_W-1:0] byte_dat,
  output logic [IDX_W-1:0]   hash_idx
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign base = clr ? CRC_SEED : crc_q;

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_octet(base, byte_dat);
    else if (clr)  crc_q <= CRC_SEED;
  end

  assign hash_idx = crc_q[CRC_W-1 -: IDX_W];

endmodule

// File: rtl/rx_dest_judge.sv
module rx_dest_judge
  import rx_dest_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_HALF  = 32,
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W,
  localparam int unsigned LO_W   = 32,
  localparam int unsigned HI_W   = ADDR_W - LO_W,
  localparam int unsigned IDX_W  = $clog2(2 * HASH_HALF),
  localparam int unsigned SEL_W  = $clog2(HASH_HALF)
) (
  input  logic [ADDR_W-1:0]    addr_flat,
  input  logic [IDX_W-1:0]     hash_idx,
  input  logic [HI_W-1:0]      stn_hi,
  input  logic [LO_W-1:0]      stn_lo,
  input  logic [HASH_HALF-1:0] hash_lo,
  input  logic [HASH_HALF-1:0] hash_hi,
  input  logic                 ctl_bcast_rej,
  input  logic                 ctl_hash_all,
  output logic                 miss_raw
);

  logic [ADDR_W-1:0]     stn;
  logic [ADDR_BYTES-1:0] byte_eq;
  logic                  is_bcast;
  logic                  use_hash;
  logic                  hash_hit;
  logic [SEL_W-1:0]      sel;

  assign stn = {stn_hi, stn_lo};

  generate
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
      assign byte_eq[i] = addr_flat[ADDR_W-1-i*OCTET_W -: OCTET_W]
                       == stn[ADDR_W-1-i*OCTET_W -: OCTET_W];
    end
  endgenerate

  assign is_bcast = &addr_flat;
  // group bit is bit 0 of the first byte
  assign use_hash = addr_flat[ADDR_W-OCTET_W] || ctl_hash_all;
  assign sel      = hash_idx[SEL_W-1:0];
  assign hash_hit = hash_idx[IDX_W-1] ? hash_hi[sel] : hash_lo[sel];

  always_comb begin
    if (is_bcast)      miss_raw = ctl_bcast_rej;
    else if (use_hash) miss_raw = !hash_hit;
    else               miss_raw = !(&byte_eq);
  end

endmodule

// File: rtl/rx_dest_screen.sv
module rx_dest_screen
  import rx_dest_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_HALF  = 32,
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W,
  localparam int unsigned HI_W   = ADDR_W - 32,
  localparam int unsigned IDX_W  = $clog2(2 * HASH_HALF)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_start,
  input  logic                 byte_vld,
  input  logic [OCTET_W-1:0]   byte_dat,
  input  logic                 frm_end,
  input  logic [HI_W-1:0]      stn_hi,
  input  logic [31:0]          stn_lo,
  input  logic [HASH_HALF-1:0] hash_lo,
  input  logic [HASH_HALF-1:0] hash_hi,
  input  logic                 ctl_bcast_rej,
  input  logic                 ctl_hash_all,
  input  logic                 ctl_promisc,
  output logic                 dec_vld,
  output logic                 accept,
  output logic                 miss
);

  logic              take;
  logic [ADDR_W-1:0] addr_flat;
  logic              done_q;
  logic              short_q;
  logic [IDX_W-1:0]  hash_idx;
  logic              miss_raw;
  logic              miss_fin;

  rx_dest_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .frm_end(frm_end), .take(take),
    .addr_flat(addr_flat), .done_q(done_q), .short_q(short_q)
  );

  rx_dest_crc #(.IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst(rst), .clr(frm_start), .take(take),
    .byte_dat(byte_dat), .hash_idx(hash_idx)
  );

  rx_dest_judge #(.ADDR_BYTES(ADDR_BYTES), .HASH_HALF(HASH_HALF)) u_judge (
    .addr_flat(addr_flat), .hash_idx(hash_idx), .stn_hi(stn_hi),
    .stn_lo(stn_lo), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .ctl_bcast_rej(ctl_bcast_rej), .ctl_hash_all(ctl_hash_all),
    .miss_raw(miss_raw)
  );

  assign miss_fin = short_q || miss_raw;

  always_ff @(posedge clk) begin
    if (rst || frm_start) begin
      dec_vld <= 1'b0;
      accept  <= 1'b0;
      miss    <= 1'b0;
    end else if (done_q) begin
      dec_vld <= 1'b1;
      miss    <= miss_fin;
      accept  <= !miss_fin || ctl_promisc;
    end
  end

endmodule

// File: rtl/rx_dest_screen_chk.sv
module rx_dest_screen_chk (
  input logic clk,
  input logic rst,
  input logic frm_start,
  input logic ctl_promisc,
  input logic dec_vld,
  input logic accept,
  input logic miss
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dec_vld |-> (!accept && !miss)); // R1

  AST_ACCEPT_RULE: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_vld) |-> (accept == (!miss || $past(ctl_promisc)))); // R8

  AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> (accept || miss)); // R8

  AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && $past(dec_vld) && !$past(frm_start)) |-> ($stable(accept) && $stable(miss))); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> !dec_vld); // R9

endmodule

bind rx_dest_screen rx_dest_screen_chk u_chk (
  .clk(clk), .rst(rst), .frm_start(frm_start), .ctl_promisc(ctl_promisc),
  .dec_vld(dec_vld), .accept(accept), .miss(miss)
);

// File: tb/rx_dest_screen_bench.sv
module rx_dest_screen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_start = 1'b0, byte_vld = 1'b0, frm_end = 1'b0;
  logic [7:0]  byte_dat = '0;
  logic [15:0] stn_hi = 16'h021A;
  logic [31:0] stn_lo = 32'h2B3C4D5E;
  logic [31:0] hash_lo = '0, hash_hi = '0;
  logic        ctl_bcast_rej = 1'b0, ctl_hash_all = 1'b0, ctl_promisc = 1'b0;
  logic        dec_vld, accept, miss;

  int n_chk = 0, n_bad = 0;
  logic early_vld;
  localparam logic [47:0] STN = 48'h021A2B3C4D5E;

  always #2 clk = ~clk;

  rx_dest_screen u_rx_dest_screen (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .frm_end(frm_end), .stn_hi(stn_hi), .stn_lo(stn_lo),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .ctl_bcast_rej(ctl_bcast_rej),
    .ctl_hash_all(ctl_hash_all), .ctl_promisc(ctl_promisc),
    .dec_vld(dec_vld), .accept(accept), .miss(miss)
  );

  function automatic logic [5:0] exp_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = r[31] ^ a[47 - 8*i - 7 + j];
        r = {r[30:0], 1'b0};
        if (fb) r = r ^ 32'h04C11DB7;
      end
    end
    return r[31:26];
  endfunction

  task automatic check(input string req, input logic ev, input logic ea, input logic em);
    n_chk++;
    if ({dec_vld, accept, miss} !== {ev, ea, em}) begin
      n_bad++;
      $display("FAIL %s: vld/acc/miss actual %b%b%b expected %b%b%b",
               req, dec_vld, accept, miss, ev, ea, em);
    end
  endtask

  // n address bytes, then 'extra' filler bytes; frm_end on the last byte
  task automatic send(input logic [47:0] a, input int n, input int extra);
    if (n + extra == 0) begin
      @(negedge clk);
      frm_start = 1'b1; byte_vld = 1'b0; frm_end = 1'b1;
    end else begin
      for (int i = 0; i < n + extra; i++) begin
        @(negedge clk);
        frm_start = (i == 0);
        byte_vld  = 1'b1;
        byte_dat  = (i < 6) ? a[47 - 8*i -: 8] : 8'hA5;
        frm_end   = (i == n + extra - 1);
      end
    end
    @(negedge clk);
    frm_start = 1'b0; byte_vld = 1'b0; frm_end = 1'b0;
    early_vld = dec_vld;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hash_set(input logic [63:0] h);
    hash_lo = h[31:0]; hash_hi = h[63:32];
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", 1'b0, 1'b0, 1'b0);

    // R6 exact station match and R2 latency
    send(STN, 6, 0);
    n_chk++;
    if (early_vld !== 1'b0) begin
      n_bad++; $display("FAIL R2 early: actual %b expected 0", early_vld);
    end
    check("R6 match", 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 hold", 1'b1, 1'b1, 1'b0);
    end
    // R9 start clears
    @(negedge clk);
    frm_start = 1'b1; byte_vld = 1'b1; byte_dat = 8'hFF;
    @(negedge clk);
    frm_start = 1'b0; byte_vld = 1'b0;
    check("R9 clear", 1'b0, 1'b0, 1'b0);

    // R6 one flipped bit per byte position
    for (int i = 0; i < 6; i++) begin
      send(STN ^ (48'h80 << (8*(5-i))), 6, 0);
      check("R6 byte mismatch", 1'b1, 1'b0, 1'b1);
    end

    // R2 trailing bytes ignored
    send(STN, 6, 5);
    check("R2 trailing", 1'b1, 1'b1, 1'b0);

    // R3 broadcast
    send('1, 6, 0);
    check("R3 bcast pass", 1'b1, 1'b1, 1'b0);
    ctl_bcast_rej = 1'b1;
    send('1, 6, 0);
    check("R3 bcast reject", 1'b1, 1'b0, 1'b1);
    ctl_promisc = 1'b1;
    send('1, 6, 0);
    check("R8 bcast promisc", 1'b1, 1'b1, 1'b1);
    ctl_promisc = 1'b0; ctl_bcast_rej = 1'b0;

    // R4 hash-all on an individual address
    ctl_hash_all = 1'b1;
    hash_set('0);
    send(STN, 6, 0);
    check("R4 hash_all empty", 1'b1, 1'b0, 1'b1);
    hash_set(64'd1 << exp_idx(STN));
    send(STN, 6, 0);
    check("R4 hash_all hit", 1'b1, 1'b1, 1'b0);
    ctl_hash_all = 1'b0;
    hash_set('0);
    send(STN | 48'h0100_0000_0000, 6, 0);
    check("R4 group empty", 1'b1, 1'b0, 1'b1);

    // R5 sweep of group addresses
    for (int k = 0; k < 64; k++) begin
      logic [47:0] a;
      logic [63:0] h;
      a = 48'h01005E000000 | 48'(k * 37);
      h = 64'd1 << exp_idx(a);
      hash_set(h);
      send(a, 6, 0);
      check("R5 hash single", 1'b1, 1'b1, 1'b0);
      hash_set(~h);
      send(a, 6, 0);
      check("R5 hash hole", 1'b1, 1'b0, 1'b1);
    end
    hash_set('0);

    // R7 short frames
    for (int n = 0; n < 6; n++) begin
      send(STN, n, 0);
      check("R7 short", 1'b1, 1'b0, 1'b1);
      ctl_promisc = 1'b1;
      send(STN, n, 0);
      check("R7 short promisc", 1'b1, 1'b1, 1'b1);
      ctl_promisc = 1'b0;
    end

    // R8 promiscuous unicast miss, R9 back-to-back restart
    ctl_promisc = 1'b1;
    send(48'h001122334455, 6, 0);
    check("R8 promisc miss", 1'b1, 1'b1, 1'b1);
    ctl_promisc = 1'b0;
    send(48'h001122334455, 6, 0);
    send(STN, 6, 0);
    check("R9 restart", 1'b1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule